// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a serial EEPROM that speaks a three-wire, clocked command protocol. The caller places a word address on `addr`, picks 6-bit or 8-bit addressing with `addr8`, sets the serial clock half-period in system clocks with `half_period`, and pulses `start`. The block then drives chip select, serial clock and data-in. It shifts out a read command and collects sixteen data bits from the device's data-out line, most significant bit first.

The command is a three-bit read opcode whose first bit is always one (binary 110). The address bits follow it. While the frame runs, `busy` is high. When the frame ends, `done` pulses for one cycle and the assembled word on `word` is valid in that same cycle. Chip select then stays low for at least one half-period before another frame can begin.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, chip select, serial clock, data-in, `busy` and `done` are all 0.
- R2: The command shifted out is 3 + W bits, MSB first, where W is the address width. Its value is (6 << W) | address, so the leading bits are 1, 1, 0, followed by the address bits.
- R3: `addr8` = 1 selects W = 8. `addr8` = 0 selects W = 6, and in that mode `addr[7:6]` are ignored.
- R4: Data-in changes only while the serial clock is low. It holds steady for the whole time the clock is high.
- R5: After the command, the clock is held low for one half-period. Then 16 data bits are sampled, MSB first, each at the end of a clock-high half-period. The result appears on `word`.
- R6: The serial clock is high only while chip select is high.
- R7: Every clock level and every framing step lasts H system clocks, where H = `half_period` captured at start (a value of 0 counts as 1). A frame takes (35 + 2·(3+W))·H cycles, measured from the accepting edge to the edge that raises `done`.
- R8: A `start` that arrives while `busy` is high is ignored. The running frame, its address and its timing are unchanged, and no extra frame follows.
- R9: `done` is high for exactly one cycle, and `word` holds the read data in that cycle.
- R10: Between consecutive frames, chip select stays low for at least H system clocks, even when `start` is held high continuously.
- R11: Chip select rises with the clock and data-in both low. It stays that way for one half-period before the first command bit.
- R12: Chip select falls only after the clock has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one word read; accepted only while idle |
| addr8 | input | 1 | 1 = 8-bit word address, 0 = 6-bit word address |
| addr | input | 8 | Word address; bits 7:6 unused in 6-bit mode |
| half_period | input | HP_W | Serial clock half-period in system clocks (0 treated as 1) |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse; `word` valid in this cycle |
| word | output | 16 | Word read from the device |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Command bits into the device |
| ee_do | input | 1 | Data bits from the device |

## Verification
The read is tried in both address widths, with the highest and lowest addresses in each. It is also tried with an address whose upper two bits are set in 6-bit mode, which shows whether those bits leak into the command. Half-periods of 0, 1, 2 and 3 separate a correct per-level hold from one that is off by one or that lets 0 stall the divider, because the measured frame length must scale exactly with H. Returned words are asymmetric and differ per address, so a reversed bit order or a sample taken one bit late yields a different word. A mid-frame `start` and a continuously held `start` tell whether a busy request is dropped and whether the inter-frame chip-select gap is kept.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_MAX = 8;
    localparam int ADDR_MIN = 6;
    localparam int OP_W     = 3;
    localparam int CMD_W    = OP_W + ADDR_MAX;
    localparam int CNT_W    = $clog2(DATA_W + 1) + 1;
    localparam logic [OP_W-1:0] READ_OP = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_TAIL
    } phase_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    // Left-aligned command: opcode, then address, then padding in 6-bit mode
    function automatic logic [CMD_W-1:0] build_cmd(input logic [ADDR_MAX-1:0] a,
                                                   input logic wide);
        logic [CMD_W-1:0] c;
        if (wide)
            c = {READ_OP, a};
        else
            c = {READ_OP, a[ADDR_MIN-1:0], {(ADDR_MAX-ADDR_MIN){1'b0}}};
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] cmd_len(input logic wide);
        return wide ? CNT_W'(OP_W + ADDR_MAX) : CNT_W'(OP_W + ADDR_MIN);
    endfunction

    function automatic pins_t pins_of(input phase_e p, input logic msb);
        pins_t o;
        o.cs = (p != ST_IDLE) && (p != ST_TAIL);
        o.sk = (p == ST_CMD_HI) || (p == ST_RD_HI);
        o.di = ((p == ST_CMD_LO) || (p == ST_CMD_HI)) && msb;
        return o;
    endfunction

endpackage

// File: rtl/eerd_halfper.sv
module eerd_halfper #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [HP_W-1:0] hp_in,
    input  logic            run,
    output logic            tick
);
    logic [HP_W-1:0] hp_q;
    logic [HP_W-1:0] cnt_q;

    assign tick = run && (cnt_q == hp_q - HP_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_q  <= HP_W'(1);
            cnt_q <= '0;
        end else begin
            if (load)
                hp_q <= (hp_in == '0) ? HP_W'(1) : hp_in;
            if (!run || tick)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + HP_W'(1);
        end
    end

    // R7: the counter never passes the captured half-period
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < hp_q));

endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
    import eerd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                addr8,
    input  logic [ADDR_MAX-1:0] addr,
    input  logic                tick,
    input  logic                ee_do,
    output logic                load,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   word,
    output logic                ee_cs,
    output logic                ee_sk,
    output logic                ee_di
);
    phase_e             st_q, st_d;
    logic [CMD_W-1:0]   sr_q, sr_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [DATA_W-1:0]  word_q, word_d;
    logic               done_d;
    pins_t              pins_q, pins_d;

    assign busy = (st_q != ST_IDLE);
    assign load = start && (st_q == ST_IDLE);

    always_comb begin
        st_d   = st_q;
        sr_d   = sr_q;
        cnt_d  = cnt_q;
        word_d = word_q;
        done_d = 1'b0;
        case (st_q)
            ST_IDLE: if (start) begin
                st_d  = ST_SEL;
                sr_d  = build_cmd(addr, addr8);
                cnt_d = cmd_len(addr8);
            end
            ST_SEL:    if (tick) st_d = ST_CMD_LO;
            ST_CMD_LO: if (tick) st_d = ST_CMD_HI;
            ST_CMD_HI: if (tick) begin
                if (cnt_q == CNT_W'(1)) begin
                    st_d  = ST_RD_LO;
                    cnt_d = CNT_W'(DATA_W);
                end else begin
                    st_d  = ST_CMD_LO;
                    cnt_d = cnt_q - CNT_W'(1);
                    sr_d  = {sr_q[CMD_W-2:0], 1'b0};
                end
            end
            ST_RD_LO: if (tick)
                st_d = (cnt_q == '0) ? ST_TAIL : ST_RD_HI;
            ST_RD_HI: if (tick) begin
                st_d   = ST_RD_LO;
                word_d = {word_q[DATA_W-2:0], ee_do};
                cnt_d  = cnt_q - CNT_W'(1);
            end
            ST_TAIL: if (tick) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign pins_d = pins_of(st_d, sr_d[CMD_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sr_q   <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            done   <= 1'b0;
            pins_q <= '0;
        end else begin
            st_q   <= st_d;
            sr_q   <= sr_d;
            cnt_q  <= cnt_d;
            word_q <= word_d;
            done   <= done_d;
            pins_q <= pins_d;
        end
    end

    assign word  = word_q;
    assign ee_cs = pins_q.cs;
    assign ee_sk = pins_q.sk;
    assign ee_di = pins_q.di;

    // R4
    di_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sk |=> (!ee_sk || $stable(ee_di)));

    // R6
    sk_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    cs_rise_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_cs) |-> (!ee_sk && !ee_di));

    // R12
    cs_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_cs) |-> (!ee_sk && !$past(ee_sk)));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && st_q != ST_TAIL) |=> busy);

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
    import eerd_pkg::*;
#(
    parameter int HP_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                addr8,
    input  logic [ADDR_MAX-1:0] addr,
    input  logic [HP_W-1:0]     half_period,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   word,
    output logic                ee_cs,
    output logic                ee_sk,
    output logic                ee_di,
    input  logic                ee_do
);
    logic tick;
    logic load;

    eerd_halfper #(.HP_W(HP_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .hp_in (half_period),
        .run   (busy),
        .tick  (tick)
    );

    eerd_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .addr8 (addr8),
        .addr  (addr),
        .tick  (tick),
        .ee_do (ee_do),
        .load  (load),
        .busy  (busy),
        .done  (done),
        .word  (word),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_di (ee_di)
    );

endmodule

// File: tb/eeprom_word_reader_test.sv
module eeprom_word_reader_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        addr8 = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  half_period = 8'd1;
    logic        busy, done;
    logic [15:0] word;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    eeprom_word_reader uut (
        .clk(clk), .rst(rst), .start(start), .addr8(addr8), .addr(addr),
        .half_period(half_period), .busy(busy), .done(done), .word(word),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] dev_word(input int a);
        logic [7:0] b;
        b = 8'(a);
        return (b == 8'h00) ? 16'h8129 : {b, ~b ^ 8'h3C};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Behavioural device: collects the command on rising clocks, then returns data bits
    bit          dev_wide = 1'b0;
    int          dev_bits = 0;
    int          dev_cmd  = 0;
    int          frames   = 0;
    logic [15:0] dev_sr   = '0;

    always @(posedge ee_cs) begin
        frames++;
        dev_bits = 0;
        dev_cmd  = 0;
        ee_do    = 1'b0;
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            if (dev_bits < (dev_wide ? 11 : 9)) begin
                dev_cmd = (dev_cmd << 1) | int'(ee_di);
                dev_bits++;
                if (dev_bits == (dev_wide ? 11 : 9))
                    dev_sr = dev_word(dev_cmd & (dev_wide ? 8'hFF : 8'h3F));
            end else begin
                ee_do  = dev_sr[15];
                dev_sr = {dev_sr[14:0], 1'b0};
                dev_bits++;
            end
        end
    end

    // Chip-select low-gap monitor
    int lowcnt = 0;
    int last_gap = -1;
    logic cs_prev = 1'b0;
    always @(negedge clk) begin
        if (!cs_prev && ee_cs) last_gap = lowcnt;
        if (!ee_cs) lowcnt++; else lowcnt = 0;
        cs_prev = ee_cs;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic do_read(input logic wide, input logic [7:0] a, input logic [7:0] hp,
                           output logic [15:0] w, output int lat);
        @(negedge clk);
        addr8 = wide; addr = a; half_period = hp; dev_wide = wide;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        w = word;
    endtask

    function automatic int exp_lat(input logic wide, input logic [7:0] hp);
        int h;
        h = (hp == 0) ? 1 : int'(hp);
        return (35 + 2 * (wide ? 11 : 9)) * h;
    endfunction

    // fields: wide, address, half-period
    localparam logic [16:0] VEC [7] = '{
        {1'b0, 8'h00, 8'd1},
        {1'b0, 8'h3F, 8'd2},
        {1'b0, 8'hC7, 8'd0},
        {1'b1, 8'hA5, 8'd1},
        {1'b1, 8'hFF, 8'd3},
        {1'b1, 8'h00, 8'd1},
        {1'b1, 8'h5A, 8'd2}
    };

    initial begin
        logic [15:0] w;
        int lat;
        int f0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(ee_cs == 0, "R1 cs", int'(ee_cs), 0);
        chk(ee_sk == 0, "R1 sk", int'(ee_sk), 0);
        chk(ee_di == 0, "R1 di", int'(ee_di), 0);
        chk(busy == 0,  "R1 busy", int'(busy), 0);
        chk(done == 0,  "R1 done", int'(done), 0);

        for (int i = 0; i < 7; i++) begin
            logic       wv;
            logic [7:0] av, hv;
            int         ea;
            {wv, av, hv} = VEC[i];
            ea = int'(av & (wv ? 8'hFF : 8'h3F));
            do_read(wv, av, hv, w, lat);
            // R2 / R3: command bits seen by the device
            chk(dev_cmd == ((6 << (wv ? 8 : 6)) | ea), wv ? "R2 R3 cmd wide" : "R2 R3 cmd narrow",
                dev_cmd, (6 << (wv ? 8 : 6)) | ea);
            // R5 / R9: word valid in the done cycle
            chk(done && w == dev_word(ea), "R5 R9 word", int'(w), int'(dev_word(ea)));
            // R7: frame length scales with the half-period
            chk(lat == exp_lat(wv, hv), "R7 latency", lat, exp_lat(wv, hv));
            @(negedge clk);
            chk(!done, "R9 done width", int'(done), 0);
        end

        // R8: start while busy is dropped
        f0 = frames;
        @(negedge clk);
        addr8 = 1'b1; addr = 8'h12; half_period = 8'd2; dev_wide = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        addr = 8'h34;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 31;
        while (!done && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
        chk(word == dev_word(8'h12), "R8 word of first request", int'(word), int'(dev_word(8'h12)));
        chk(lat == exp_lat(1'b1, 8'd2), "R8 timing unchanged", lat, exp_lat(1'b1, 8'd2));
        repeat (10) @(negedge clk);
        chk(frames - f0 == 1, "R8 single frame", frames - f0, 1);
        chk(!busy, "R8 no extra frame", int'(busy), 0);

        // R10: start held high, back-to-back frames keep a chip-select gap
        f0 = frames;
        addr8 = 1'b0; addr = 8'h21; half_period = 8'd2; dev_wide = 1'b0;
        start = 1'b1;
        lat = 0;
        while (frames - f0 < 2 && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
        chk(last_gap >= 2, "R10 cs gap", last_gap, 2);
        chk(word == dev_word(8'h21), "R10 second word", int'(word), int'(dev_word(8'h21)));

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule